// File: doc/BRIEF.md
# Wilkinson Conversion Controller

This block is the digital half of a single-ramp converter that serves a whole array of analog storage cells at once. While the array is in its sampling mode the write enable stays high. A trigger ends sampling and sends a one-cycle ramp start strobe to the shared analog ramp. It then runs one common 12-bit counter from the fast conversion clock. Each cell has a comparator that flips when the ramp crosses its stored voltage. The block catches the first rising edge of every comparator and stores the counter value of that moment as the cell's code.

When the counter reaches full scale the conversion ends. The block gives a one-cycle completion pulse and holds a ready level for the readout logic. It then serves codes by address until readout signals completion, and after that it returns to sampling. The analog ramp, the comparators and the oscillator are outside the block. They appear only as the strobe, the comparator bits and the clock.

Top module: `wadc_conv_ctrl`

## Requirements
- R1: After reset, write_en is 1, and conv_active, ramp_start, conv_done, conv_ready and rd_data are all 0.
- R2: A trigger sampled while write_en is 1 gives, one clock later, write_en 0, conv_active 1 and ramp_start 1. ramp_start lasts exactly one cycle. The counter reads 0 after that accepting edge and goes up by one on every later edge.
- R3: A trigger sampled while write_en is 0 has no effect. It does not restart the counter and does not pulse ramp_start.
- R4: Each comparator bit passes through two flops before edge detection. If a comparator rises between the edges after which the counter shows j and j+1, the stored code is j+2 (for j+2 up to 4095).
- R5: Only the first rising edge of a comparator in a conversion is stored. Later toggles in the same conversion leave the code unchanged.
- R6: A cell with no captured rising edge in a conversion holds code 0xFFF. This includes a comparator that was already high when the trigger arrived.
- R7: conv_active falls, and conv_done is high for exactly one cycle, in the cycle after the 4096th edge that follows the accepting edge.
- R8: conv_ready rises together with conv_done. It stays high until rd_start or rd_done is sampled in read mode.
- R9: In read mode, rd_data shows the code of cell rd_addr one clock after the address is sampled, where rd_addr = channel*256 + cell. Outside read mode, rd_data holds its value.
- R10: rd_done sampled in read mode sets write_en back to 1 one clock later. rd_start and rd_done have no effect outside read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; clocks the counter and all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | Ends sampling and starts a conversion |
| comp_in | input | 1024 | Comparator output of every cell, channel-major |
| rd_start | input | 1 | Readout has begun; clears the ready level |
| rd_done | input | 1 | Readout finished; return to sampling |
| rd_addr | input | 10 | Cell selected for readout |
| write_en | output | 1 | Sampling (write) switches enabled |
| ramp_start | output | 1 | One-cycle strobe that starts the common ramp |
| conv_active | output | 1 | Conversion in progress |
| conv_done | output | 1 | One-cycle pulse at the end of conversion |
| conv_ready | output | 1 | Codes valid and readout not yet begun |
| rd_data | output | 12 | Registered code of the addressed cell |

## Verification
A counter that starts from the wrong value or misses a step shifts every code by the same amount. This shows on the first word read back. It also moves the conv_done pulse away from its exact cycle 4096 edges after the trigger. A wrong synchronizer depth moves every code by one, so the bench places cells at known counter values, including the first and last capturable counts. A capture flag that is not cleared or not honoured shows up only in cells that toggle more than once or never fire. For that reason the patterns include toggling, silent and pre-raised comparators, and the whole array is read back after each conversion.

// File: rtl/wadc_pkg.sv
package wadc_pkg;
    typedef enum logic [1:0] {
        ST_WRITE   = 2'd0,
        ST_CONVERT = 2'd1,
        ST_READ    = 2'd2
    } mode_e;
endpackage

// File: rtl/wadc_seq.sv
// Mode sequencer and the shared conversion counter.
module wadc_seq #(
    parameter int CNT_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trigger,
    input  logic                 rd_start,
    input  logic                 rd_done,
    output wadc_pkg::mode_e      mode,
    output logic [CNT_W-1:0]     count,
    output logic                 clear_cells,
    output logic                 ramp_start,
    output logic                 conv_done,
    output logic                 conv_ready
);
    import wadc_pkg::*;

    localparam logic [CNT_W-1:0] FULL_SCALE = {CNT_W{1'b1}};

    typedef struct packed {
        mode_e            mode;
        logic [CNT_W-1:0] count;
        logic             ramp;
        logic             done;
        logic             ready;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.ramp = 1'b0;
        seq_d.done = 1'b0;
        unique case (seq_q.mode)
            ST_WRITE: begin
                if (trigger) begin
                    seq_d.mode  = ST_CONVERT;
                    seq_d.count = '0;
                    seq_d.ramp  = 1'b1;
                end
            end
            ST_CONVERT: begin
                if (seq_q.count == FULL_SCALE) begin
                    seq_d.mode  = ST_READ;
                    seq_d.done  = 1'b1;
                    seq_d.ready = 1'b1;
                end else begin
                    seq_d.count = seq_q.count + 1'b1;
                end
            end
            ST_READ: begin
                if (rd_start || rd_done) seq_d.ready = 1'b0;
                if (rd_done)             seq_d.mode  = ST_WRITE;
            end
            default: seq_d.mode = ST_WRITE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{mode: ST_WRITE, count: '0, ramp: 1'b0, done: 1'b0, ready: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mode        = seq_q.mode;
    assign count       = seq_q.count;
    assign clear_cells = (seq_q.mode == ST_WRITE) && trigger;
    assign ramp_start  = seq_q.ramp;
    assign conv_done   = seq_q.done;
    assign conv_ready  = seq_q.ready;
endmodule

// File: rtl/wadc_sync_edge.sv
// Two-flop synchronizer followed by a rising-edge detector.
module wadc_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1   = async_in;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise = sync_q.s2 & ~sync_q.prev;
endmodule

// File: rtl/wadc_cell.sv
// Per-cell code register: first edge wins, preset to the overflow code.
module wadc_cell #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             capture_en,
    input  logic             rise,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] code
);
    typedef struct packed {
        logic             hit;
        logic [CNT_W-1:0] code;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (clear) begin
            cell_d.hit  = 1'b0;
            cell_d.code = '1;
        end else if (capture_en && rise && !cell_q.hit) begin
            cell_d.hit  = 1'b1;
            cell_d.code = count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= '{hit: 1'b0, code: '1};
        else        cell_q <= cell_d;
    end

    assign code = cell_q.code;
endmodule

// File: rtl/wadc_conv_ctrl.sv
module wadc_conv_ctrl #(
    parameter int NUM_CH       = 4,
    parameter int CELLS_PER_CH = 256,
    parameter int CNT_W        = 12,
    localparam int NCELL       = NUM_CH * CELLS_PER_CH,
    localparam int ADDR_W      = $clog2(NCELL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trigger,
    input  logic [NCELL-1:0]  comp_in,
    input  logic              rd_start,
    input  logic              rd_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              write_en,
    output logic              ramp_start,
    output logic              conv_active,
    output logic              conv_done,
    output logic              conv_ready,
    output logic [CNT_W-1:0]  rd_data
);
    import wadc_pkg::*;

    mode_e            mode;
    logic [CNT_W-1:0] count;
    logic             clear_cells;
    logic             capture_en;
    logic [NCELL-1:0] rise_w;
    logic [CNT_W-1:0] codes [NCELL];
    logic [CNT_W-1:0] rd_data_d, rd_data_q;

    wadc_seq #(.CNT_W(CNT_W)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .trigger     (trigger),
        .rd_start    (rd_start),
        .rd_done     (rd_done),
        .mode        (mode),
        .count       (count),
        .clear_cells (clear_cells),
        .ramp_start  (ramp_start),
        .conv_done   (conv_done),
        .conv_ready  (conv_ready)
    );

    assign capture_en = (mode == ST_CONVERT);

    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        wadc_sync_edge i_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (comp_in[g]),
            .rise     (rise_w[g])
        );
        wadc_cell #(.CNT_W(CNT_W)) i_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear      (clear_cells),
            .capture_en (capture_en),
            .rise       (rise_w[g]),
            .count      (count),
            .code       (codes[g])
        );
    end

    always_comb begin
        rd_data_d = rd_data_q;
        if (mode == ST_READ) rd_data_d = codes[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data_q <= '0;
        else        rd_data_q <= rd_data_d;
    end

    assign write_en    = (mode == ST_WRITE);
    assign conv_active = capture_en;
    assign rd_data     = rd_data_q;
endmodule

// File: rtl/wadc_conv_ctrl_chk.sv
module wadc_conv_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic trigger,
    input logic rd_start,
    input logic rd_done,
    input logic write_en,
    input logic ramp_start,
    input logic conv_active,
    input logic conv_done,
    input logic conv_ready
);
    // R2
    trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        write_en && trigger |=> ramp_start && conv_active && !write_en);

    // R2
    ramp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_start |=> !ramp_start);

    // R3
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !write_en |=> !ramp_start);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);

    // R7
    end_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_active) |-> conv_done);

    // R8
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> conv_ready);

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_ready && !rd_start && !rd_done |=> conv_ready);

    // R10
    back_to_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(write_en) |-> $past(rd_done));

    // R10
    mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(write_en && conv_active));
endmodule

bind wadc_conv_ctrl wadc_conv_ctrl_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trigger     (trigger),
    .rd_start    (rd_start),
    .rd_done     (rd_done),
    .write_en    (write_en),
    .ramp_start  (ramp_start),
    .conv_active (conv_active),
    .conv_done   (conv_done),
    .conv_ready  (conv_ready)
);

// File: tb/test_wadc_conv_ctrl.sv
module test_wadc_conv_ctrl;
    localparam int NCELL = 1024;
    localparam int FULL  = 4095;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trigger = 1'b0;
    logic [NCELL-1:0] comp = '0;
    logic             rd_start = 1'b0;
    logic             rd_done = 1'b0;
    logic [9:0]       rd_addr = '0;
    logic             write_en, ramp_start, conv_active, conv_done, conv_ready;
    logic [11:0]      rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int exp_code [NCELL];
    int rise1 [NCELL];
    int fall1 [NCELL];
    int rise2 [NCELL];
    bit preset [NCELL];
    int last_rd = 0;

    typedef struct {
        int cyc;
        int addr;
        int exp;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wadc_conv_ctrl i_wadc_conv_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .trigger     (trigger),
        .comp_in     (comp),
        .rd_start    (rd_start),
        .rd_done     (rd_done),
        .rd_addr     (rd_addr),
        .write_en    (write_en),
        .ramp_start  (ramp_start),
        .conv_active (conv_active),
        .conv_done   (conv_done),
        .conv_ready  (conv_ready),
        .rd_data     (rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops the expected code one cycle after the address was driven.
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].cyc == cyc - 1) begin
            item_t it;
            it = sb_q.pop_front();
            chk($sformatf("R9/R4 cell %0d", it.addr), 32'(rd_data), 32'(it.exp));
        end
    end

    task automatic plan_cells(input int seed);
        for (int i = 0; i < NCELL; i++) begin
            int t;
            t = ((i * 37 + seed * 101) % 4090) + 2;
            rise1[i] = -1; fall1[i] = -1; rise2[i] = -1; preset[i] = 1'b0;
            if (i == 0) t = 2;
            if (i == NCELL - 1) t = FULL;
            if (i % 17 == 5 && i != 0 && i != NCELL - 1) begin
                exp_code[i] = 'hFFF;                 // R6 never fires
            end else if (i % 29 == 3) begin
                preset[i] = 1'b1;                    // R6 high before trigger
                exp_code[i] = 'hFFF;
            end else begin
                rise1[i] = t - 2;                    // R4 code = j + 2
                exp_code[i] = t;
                if (i % 11 == 1 && t + 5 <= FULL) begin
                    fall1[i] = t + 1;                // R5 second edge ignored
                    rise2[i] = t + 5;
                end
            end
        end
    endtask

    task automatic run_conversion(input int seed);
        plan_cells(seed);
        @(negedge clk);
        for (int i = 0; i < NCELL; i++) comp[i] = preset[i];
        repeat (4) @(negedge clk);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        chk("R2 write_en low", 32'(write_en), 0);
        chk("R2 conv_active", 32'(conv_active), 1);
        chk("R2 ramp_start", 32'(ramp_start), 1);
        for (int k = 0; k <= FULL + 1; k++) begin
            if (k > 0) @(negedge clk);
            for (int i = 0; i < NCELL; i++) begin
                if (rise1[i] == k || rise2[i] == k) comp[i] = 1'b1;
                if (fall1[i] == k) comp[i] = 1'b0;
            end
            if (k == 1) chk("R2 ramp one cycle", 32'(ramp_start), 0);
            if (k == 100) begin
                trigger = 1'b1; rd_start = 1'b1; rd_done = 1'b1;
                rd_addr = 10'(seed * 7 + 3);
            end
            if (k == 101) begin
                trigger = 1'b0; rd_start = 1'b0; rd_done = 1'b0;
                chk("R3 no ramp on late trigger", 32'(ramp_start), 0);
                chk("R10 rd_done ignored in conversion", 32'(write_en), 0);
            end
            if (k == 102) chk("R9 rd_data holds outside read", 32'(rd_data), 32'(last_rd));
            if (k == FULL) begin
                chk("R7 still active", 32'(conv_active), 1);
                chk("R7 no early done", 32'(conv_done), 0);
            end
            if (k == FULL + 1) begin
                chk("R7 active falls", 32'(conv_active), 0);
                chk("R7 done pulse", 32'(conv_done), 1);
                chk("R8 ready rises", 32'(conv_ready), 1);
            end
        end
        @(negedge clk);
        chk("R7 done one cycle", 32'(conv_done), 0);
        repeat (3) @(negedge clk);
        chk("R8 ready held", 32'(conv_ready), 1);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        chk("R3 trigger ignored in read", 32'(conv_active), 0);
        chk("R3 no ramp in read", 32'(ramp_start), 0);
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        chk("R8 ready clears on rd_start", 32'(conv_ready), 0);
        for (int i = 0; i < NCELL; i++) begin
            item_t it;
            if (i > 0) @(negedge clk);
            rd_addr = 10'(i);
            it.cyc = cyc; it.addr = i; it.exp = exp_code[i];
            sb_q.push_back(it);
        end
        last_rd = exp_code[NCELL - 1];
        @(negedge clk);
        @(negedge clk);
        chk("R9 scoreboard drained", 32'(sb_q.size()), 0);
        chk("R10 still reading", 32'(write_en), 0);
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        chk("R10 back to write", 32'(write_en), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 write_en", 32'(write_en), 1);
        chk("R1 conv_active", 32'(conv_active), 0);
        chk("R1 ramp_start", 32'(ramp_start), 0);
        chk("R1 conv_done", 32'(conv_done), 0);
        chk("R1 conv_ready", 32'(conv_ready), 0);
        chk("R1 rd_data", 32'(rd_data), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd_start = 1'b1; rd_done = 1'b1;
        @(negedge clk);
        rd_start = 1'b0; rd_done = 1'b0;
        chk("R10 rd_done ignored in write", 32'(write_en), 1);
        chk("R10 no conversion from readout strobes", 32'(conv_active), 0);
        run_conversion(1);
        run_conversion(2);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule